// File: doc/BRIEF.md
# Triggered Shadow Commit Controller

This block owns one control register of a slave device on a serial control bus. The register carries a two-bit power-mode field, three per-group trigger masks and three trigger bits. Downstream shadow registers hold buffered data for three trigger groups. This block decides when each group's buffered data is moved into its destination register, and it signals that move with a one-cycle commit pulse.

A frame decoder presents each write to this register address as a single-cycle strobe. The strobe comes with the data byte and the slave ID carried in the frame. The block compares that ID with the device's unique ID and group ID and with the broadcast value 0. The result decides whether the write is accepted and which fields it may change. It also decides whether the trigger bits are gated by the masks already stored or by the masks carried in the same write. A group whose stored mask is set bypasses triggering: its pending data is committed as soon as the shadow side reports it.

Top module: `trig_commit_ctrl`

## Requirements
- R1: After reset the power mode is 00, all three stored masks are 0 and no commit pulse is asserted.
- R2: A write is accepted when its slave ID is 0 (broadcast), else when it equals the unique ID (unique access), else when it equals the group ID (group access). Any other write changes no state and produces no commit pulse.
- R3: The stored masks (data bits [5:3] for groups 2..0) change only on an accepted unique write. Broadcast and group writes leave them unchanged.
- R4: Any accepted write loads data bits [7:6] into the power mode, except the reserved value 11. Writing 11 leaves the power mode unchanged.
- R5: On a unique write, trigger bit g (data bit g, for g = 0..2) is gated by mask bit g+3 of the same write. If the trigger bit is 1 and that mask bit is 0, commit_o[g] is 1 in the cycle after the write. The stored masks do not take part in this gating.
- R6: On a broadcast or group write, trigger bit g is gated by the stored mask for group g as it was before the write.
- R7: A group whose stored mask is 1 commits directly: commit_o[g] is 1 in the cycle after pend_i[g] is 1, with no trigger write needed. When all three masks are 1, every pending group commits this way.
- R8: Trigger bits are not stored. One trigger write produces a commit pulse of exactly one cycle, and the pulse ends even if no further write follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | One-cycle strobe: a write to this register was decoded |
| wr_data_i | input | 8 | Write data: [7:6] power mode, [5:3] masks 2..0, [2:0] triggers 2..0 |
| wr_sid_i | input | 4 | Slave ID carried by the write frame |
| usid_i | input | 4 | Unique slave ID of this device |
| gsid_i | input | 4 | Group slave ID of this device |
| pend_i | input | 3 | Per-group indication that shadow data is pending |
| pwr_mode_o | output | 2 | Current power mode |
| mask_o | output | 3 | Stored trigger masks, bit g for group g |
| commit_o | output | 3 | Per-group commit pulse, registered |

## Verification
The assertions rely on three assumptions about the inputs. The decoder raises the write strobe for at most one cycle per frame. The unique ID is nonzero and differs from the group ID. The ID, data and pending inputs are stable around the sampling edge. The stimulus changes inputs only on the falling clock edge and drops the strobe after one cycle. It uses a unique ID of 5 and a group ID of A. It includes one write with a foreign ID, 3, to cover the ignore case. Pending inputs are raised only in idle cycles or alongside a single write, so both commit sources, trigger and direct, can be predicted cycle by cycle.

// File: rtl/trig_pkg.sv
package trig_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_BCAST = 2'd1,
    ACC_GROUP = 2'd2,
    ACC_UNIQ  = 2'd3
  } acc_e;
endpackage

// File: rtl/trig_sid_classify.sv
module trig_sid_classify
  import trig_pkg::*;
#(
  parameter int SID_W = 4
) (
  input  logic [SID_W-1:0] sid_i,
  input  logic [SID_W-1:0] usid_i,
  input  logic [SID_W-1:0] gsid_i,
  output acc_e             acc_o
);
  localparam logic [SID_W-1:0] SID_BCAST = '0;

  // broadcast first, then own unique ID, then group ID
  always_comb begin
    if (sid_i == SID_BCAST)   acc_o = ACC_BCAST;
    else if (sid_i == usid_i) acc_o = ACC_UNIQ;
    else if (sid_i == gsid_i) acc_o = ACC_GROUP;
    else                      acc_o = ACC_NONE;
  end
endmodule

// File: rtl/trig_mode_reg.sv
module trig_mode_reg
  import trig_pkg::*;
#(
  parameter int PM_W = 2,
  parameter int NGRP = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  acc_e            acc_i,
  input  logic [PM_W-1:0] pm_wr_i,
  input  logic [NGRP-1:0] mask_wr_i,
  output logic [PM_W-1:0] pm_o,
  output logic [NGRP-1:0] mask_o
);
  localparam logic [PM_W-1:0] PM_RSVD = '1;

  logic wr_acc, wr_uniq;
  assign wr_acc  = wr_en_i && (acc_i != ACC_NONE);
  assign wr_uniq = wr_en_i && (acc_i == ACC_UNIQ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pm_o <= '0;
    end else if (wr_acc && (pm_wr_i != PM_RSVD)) begin
      pm_o <= pm_wr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '0;
    end else if (wr_uniq) begin
      mask_o <= mask_wr_i;
    end
  end

  // R3
  mask_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mask_o) |-> $past(wr_en_i) && ($past(acc_i) == ACC_UNIQ));

  // R4
  pm_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pm_o) |-> $past(wr_en_i) && ($past(acc_i) != ACC_NONE)
                       && ($past(pm_wr_i) != PM_RSVD));

  // R2
  ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (acc_i == ACC_NONE) |=> $stable(pm_o) && $stable(mask_o));
endmodule

// File: rtl/trig_commit_gen.sv
module trig_commit_gen
  import trig_pkg::*;
#(
  parameter int NGRP = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  acc_e            acc_i,
  input  logic [NGRP-1:0] trig_wr_i,
  input  logic [NGRP-1:0] mask_wr_i,
  input  logic [NGRP-1:0] mask_q_i,
  input  logic [NGRP-1:0] pend_i,
  output logic [NGRP-1:0] commit_o
);
  logic wr_acc, wr_uniq;
  assign wr_acc  = wr_en_i && (acc_i != ACC_NONE);
  assign wr_uniq = (acc_i == ACC_UNIQ);

  logic [NGRP-1:0] fire;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic eff_mask;
    // unique writes gate with their own mask bits, others with stored ones
    assign eff_mask = wr_uniq ? mask_wr_i[g] : mask_q_i[g];
    assign fire[g]  = wr_acc && trig_wr_i[g] && !eff_mask;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) commit_o[g] <= 1'b0;
      else         commit_o[g] <= fire[g] || (mask_q_i[g] && pend_i[g]);
    end

    // R5 R6
    commit_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      commit_o[g] && !($past(mask_q_i[g]) && $past(pend_i[g])) |-> $past(fire[g]));

    // R8
    pulse_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      commit_o[g] && !wr_en_i && !pend_i[g] |=> !commit_o[g]);
  end
endmodule

// File: rtl/trig_commit_ctrl.sv
module trig_commit_ctrl
  import trig_pkg::*;
#(
  parameter int PM_W  = 2,
  parameter int NGRP  = 3,
  parameter int SID_W = 4,
  localparam int DW   = PM_W + 2 * NGRP
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [SID_W-1:0] wr_sid_i,
  input  logic [SID_W-1:0] usid_i,
  input  logic [SID_W-1:0] gsid_i,
  input  logic [NGRP-1:0]  pend_i,
  output logic [PM_W-1:0]  pwr_mode_o,
  output logic [NGRP-1:0]  mask_o,
  output logic [NGRP-1:0]  commit_o
);
  localparam int TRIG_LO = 0;
  localparam int MASK_LO = NGRP;
  localparam int PM_LO   = 2 * NGRP;

  acc_e            acc;
  logic [NGRP-1:0] trig_wr, mask_wr;
  logic [PM_W-1:0] pm_wr;

  assign trig_wr = wr_data_i[TRIG_LO +: NGRP];
  assign mask_wr = wr_data_i[MASK_LO +: NGRP];
  assign pm_wr   = wr_data_i[PM_LO +: PM_W];

  trig_sid_classify #(.SID_W(SID_W)) u_cls (
    .sid_i  (wr_sid_i),
    .usid_i (usid_i),
    .gsid_i (gsid_i),
    .acc_o  (acc)
  );

  trig_mode_reg #(.PM_W(PM_W), .NGRP(NGRP)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .acc_i     (acc),
    .pm_wr_i   (pm_wr),
    .mask_wr_i (mask_wr),
    .pm_o      (pwr_mode_o),
    .mask_o    (mask_o)
  );

  trig_commit_gen #(.NGRP(NGRP)) u_cmt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .acc_i     (acc),
    .trig_wr_i (trig_wr),
    .mask_wr_i (mask_wr),
    .mask_q_i  (mask_o),
    .pend_i    (pend_i),
    .commit_o  (commit_o)
  );

  // R7
  direct_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_o & pend_i) != '0 |=> (commit_o & $past(mask_o & pend_i)) == $past(mask_o & pend_i));

  // R2
  foreign_sid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (wr_sid_i != '0) && (wr_sid_i != usid_i) && (wr_sid_i != gsid_i)
      && ((mask_o & pend_i) == '0) |=> commit_o == '0);
endmodule

// File: tb/sim_trig_commit_ctrl.sv
module sim_trig_commit_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [3:0] wr_sid_i = '0;
  logic [3:0] usid_i = 4'h5;
  logic [3:0] gsid_i = 4'hA;
  logic [2:0] pend_i = '0;
  logic [1:0] pwr_mode_o;
  logic [2:0] mask_o;
  logic [2:0] commit_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  trig_commit_ctrl u0 (.*);

  typedef struct {
    logic [1:0] pm;
    logic [2:0] mask;
    logic [2:0] commit;
    string      tag;
  } exp_t;

  exp_t sb[$];

  // drive one cycle at negedge; expected values appear after next posedge
  task automatic step(input logic en, input logic [7:0] d, input logic [3:0] sid,
                      input logic [2:0] pend, input logic [1:0] epm,
                      input logic [2:0] emask, input logic [2:0] ecmt, input string tag);
    exp_t e;
    @(negedge clk_i);
    wr_en_i = en; wr_data_i = d; wr_sid_i = sid; pend_i = pend;
    e.pm = epm; e.mask = emask; e.commit = ecmt; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: sample mid high phase
  initial begin
    forever begin
      @(posedge clk_i);
      #5;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (pwr_mode_o !== e.pm || mask_o !== e.mask || commit_o !== e.commit) begin
          errors++;
          $display("FAIL %s: pm=%b mask=%b commit=%b expected pm=%b mask=%b commit=%b",
                   e.tag, pwr_mode_o, mask_o, commit_o, e.pm, e.mask, e.commit);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    checks++;
    if (pwr_mode_o !== 2'b00 || mask_o !== 3'b000 || commit_o !== 3'b000) begin
      errors++;
      $display("FAIL R1 reset: pm=%b mask=%b commit=%b expected 00 000 000",
               pwr_mode_o, mask_o, commit_o);
    end
    rst_ni = 1'b1;
    step(1, 8'b01_000_111, 4'h0, 3'b000, 2'b01, 3'b000, 3'b111, "R6 R4 bcast trig, stored masks 0");
    step(0, 8'h00, 4'h0, 3'b000, 2'b01, 3'b000, 3'b000, "R8 pulse ends");
    step(1, 8'b00_101_111, 4'h5, 3'b000, 2'b00, 3'b101, 3'b010, "R5 unique gated by own masks");
    step(0, 8'h00, 4'h0, 3'b000, 2'b00, 3'b101, 3'b000, "R8 idle");
    step(1, 8'b10_111_111, 4'h0, 3'b000, 2'b10, 3'b101, 3'b010, "R3 R6 bcast keeps masks");
    step(1, 8'b11_111_001, 4'hA, 3'b000, 2'b10, 3'b101, 3'b000, "R4 group write pm 11 ignored");
    step(1, 8'b00_000_010, 4'hA, 3'b000, 2'b00, 3'b101, 3'b010, "R6 group trig");
    step(1, 8'b01_000_111, 4'h3, 3'b000, 2'b00, 3'b101, 3'b000, "R2 foreign sid ignored");
    step(0, 8'h00, 4'h0, 3'b111, 2'b00, 3'b101, 3'b101, "R7 direct commit masked groups");
    step(1, 8'b00_111_000, 4'h5, 3'b000, 2'b00, 3'b111, 3'b000, "R3 unique sets all masks");
    step(0, 8'h00, 4'h0, 3'b111, 2'b00, 3'b111, 3'b111, "R7 all masked commit");
    step(1, 8'b11_000_111, 4'h5, 3'b000, 2'b00, 3'b000, 3'b111, "R5 R4 unique ignores stored masks");
    step(1, 8'b00_010_110, 4'h5, 3'b000, 2'b00, 3'b010, 3'b100, "R5 partial mask");
    step(1, 8'b00_000_011, 4'h0, 3'b010, 2'b00, 3'b010, 3'b011, "R6 R7 bcast plus direct");
    step(0, 8'h00, 4'h0, 3'b000, 2'b00, 3'b010, 3'b000, "R8 final idle");
    @(negedge clk_i);
    wr_en_i = 1'b0;
    repeat (3) @(negedge clk_i);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule